// File: doc/BRIEF.md
# Hierarchical Scan Observation Tree

This block collects the value of one cell out of a rectangular grid of randomly addressable scan cells and presents it on a single observation pin. A cell is picked by the intersection of a row select line and a column select line. The selected cell's value travels up a tree of four-input selector nodes. Each node passes on one data bit and a flag that says whether any of its four inputs was selected. Nodes are stacked level by level until one node remains, and that node drives the block output.

Each node can have a register on both of its outputs. With the registers in place, every level adds one clock of latency and the tree accepts a new selection on every clock, so long observation buses can be pipelined. Without them, the tree is purely combinational. Grids whose cell count is not a power of four leave the spare node inputs tied inactive.

Top module: `scan_obs_tree`

## Requirements
- R1: Cell index i = r*COLS + c is selected when `row_sel[r]` and `col_sel[c]` are both 1, and bit i of `cell_data` is its value; a single selected cell appears on `scan_out` with `scan_valid` = 1.
- R2: When no cell is selected, `scan_valid` is 0 and `scan_out` is 0, whatever `cell_data` holds.
- R3: When several cells are selected at once, the one with the lowest index i is observed.
- R4: With PIPELINE = 1, a selection applied before a clock edge is observed after exactly LEVELS edges, where LEVELS = ceil(log4(ROWS*COLS)) and is at least 1 (3 for an 8x8 grid). A new selection is accepted on every cycle.
- R5: `scan_valid` stays aligned with its data: it is 1 exactly when the selection applied LEVELS cycles earlier hit at least one cell.
- R6: The synchronous active-high reset clears every pipeline register. On the edge after reset, both outputs are 0, and selections held during reset are never observed.
- R7: With PIPELINE = 0, the outputs follow the inputs within the same cycle, with the same selection rules.
- R8: A grid whose cell count is not a power of four (for example 5x5) observes every cell, including the highest index. Padded node inputs never raise `scan_valid`.
- R9: The values of unselected cells have no effect on `scan_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_sel | input | ROWS | Row select lines, one per grid row |
| col_sel | input | COLS | Column select lines, one per grid column |
| cell_data | input | ROWS*COLS | Cell values, bit r*COLS+c for row r, column c |
| scan_out | output | 1 | Observed cell value |
| scan_valid | output | 1 | High when scan_out carries a selected cell |

## Verification
Two situations can coincide within a single cycle. One is a collision between selections, where several rows or columns are active together and the lowest-index rule must settle the result. The other is a reset that lands while earlier selections are still moving through the pipelined tree. The bench applies random multi-row and multi-column selections back to back. It also asserts reset while the pipeline is full. A behavioural reference pipeline, which is cleared by the same reset, is compared with the outputs on every clock. A second, unregistered 5x5 instance is checked in the same cycle as its stimulus.

// File: rtl/scan_obs_pkg.sv
package scan_obs_pkg;

  // Number of four-input levels needed to reduce n inputs to one (at least 1).
  function automatic int unsigned levels_for(input int unsigned n);
    int unsigned lv;
    int unsigned span;
    lv = 1;
    span = 4;
    while (span < n) begin
      span = span * 4;
      lv = lv + 1;
    end
    return lv;
  endfunction

  // Width of the bus entering level k when the leaf has n inputs.
  function automatic int unsigned width_at(input int unsigned n, input int unsigned k);
    int unsigned w;
    w = n;
    for (int unsigned i = 0; i < k; i++) begin
      w = (w + 3) / 4;
    end
    return w;
  endfunction

endpackage

// File: rtl/scan_obs_decode.sv
module scan_obs_decode #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 8
) (
  input  logic [ROWS-1:0]      row_sel,
  input  logic [COLS-1:0]      col_sel,
  output logic [ROWS*COLS-1:0] cell_hit
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign cell_hit[r*COLS + c] = row_sel[r] & col_sel[c];
    end
  end

endmodule

// File: rtl/scan_obs_node.sv
module scan_obs_node #(
  parameter bit REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] in_d,
  input  logic [3:0] in_v,
  output logic       out_d,
  output logic       out_v
);

  logic pick_d;
  logic pick_v;

  // Lowest-index active input wins; zero data when none is active.
  always_comb begin
    pick_d = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      if (in_v[i]) pick_d = in_d[i];
    end
    pick_v = |in_v;
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_d <= 1'b0;
        out_v <= 1'b0;
      end else begin
        out_d <= pick_d;
        out_v <= pick_v;
      end
    end
  end else begin : g_comb
    assign out_d = pick_d;
    assign out_v = pick_v;
  end

endmodule

// File: rtl/scan_obs_level.sv
module scan_obs_level #(
  parameter int unsigned IN_W = 64,
  parameter bit          REG  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [IN_W-1:0]        in_d,
  input  logic [IN_W-1:0]        in_v,
  output logic [(IN_W+3)/4-1:0]  out_d,
  output logic [(IN_W+3)/4-1:0]  out_v
);

  localparam int unsigned OUT_W = (IN_W + 3) / 4;
  localparam int unsigned PAD_W = OUT_W * 4;

  logic [PAD_W-1:0] pad_d;
  logic [PAD_W-1:0] pad_v;

  // Spare inputs of a partly filled level are inactive.
  assign pad_d = PAD_W'(in_d);
  assign pad_v = PAD_W'(in_v);

  for (genvar j = 0; j < OUT_W; j++) begin : g_node
    scan_obs_node #(.REG(REG)) u_node (
      .clk  (clk),
      .rst  (rst),
      .in_d (pad_d[4*j +: 4]),
      .in_v (pad_v[4*j +: 4]),
      .out_d(out_d[j]),
      .out_v(out_v[j])
    );
  end

endmodule

// File: rtl/scan_obs_tree.sv
module scan_obs_tree
  import scan_obs_pkg::*;
#(
  parameter int unsigned ROWS     = 8,
  parameter int unsigned COLS     = 8,
  parameter bit          PIPELINE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROWS-1:0]      row_sel,
  input  logic [COLS-1:0]      col_sel,
  input  logic [ROWS*COLS-1:0] cell_data,
  output logic                 scan_out,
  output logic                 scan_valid
);

  localparam int unsigned CELLS  = ROWS * COLS;
  localparam int unsigned LEVELS = levels_for(CELLS);

  logic [CELLS-1:0] leaf_v;

  scan_obs_decode #(.ROWS(ROWS), .COLS(COLS)) u_decode (
    .row_sel (row_sel),
    .col_sel (col_sel),
    .cell_hit(leaf_v)
  );

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int unsigned W_IN  = width_at(CELLS, k);
    localparam int unsigned W_OUT = width_at(CELLS, k + 1);

    logic [W_IN-1:0]  lv_in_d;
    logic [W_IN-1:0]  lv_in_v;
    logic [W_OUT-1:0] lv_out_d;
    logic [W_OUT-1:0] lv_out_v;

    if (k == 0) begin : g_leaf
      assign lv_in_d = cell_data;
      assign lv_in_v = leaf_v;
    end else begin : g_inner
      assign lv_in_d = g_lvl[k-1].lv_out_d;
      assign lv_in_v = g_lvl[k-1].lv_out_v;
    end

    scan_obs_level #(.IN_W(W_IN), .REG(PIPELINE)) u_level (
      .clk  (clk),
      .rst  (rst),
      .in_d (lv_in_d),
      .in_v (lv_in_v),
      .out_d(lv_out_d),
      .out_v(lv_out_v)
    );
  end

  assign scan_out   = g_lvl[LEVELS-1].lv_out_d[0];
  assign scan_valid = g_lvl[LEVELS-1].lv_out_v[0];

endmodule

// File: rtl/scan_obs_tree_chk.sv
module scan_obs_tree_chk
  import scan_obs_pkg::*;
#(
  parameter int unsigned ROWS     = 8,
  parameter int unsigned COLS     = 8,
  parameter bit          PIPELINE = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ROWS-1:0]      row_sel,
  input logic [COLS-1:0]      col_sel,
  input logic [ROWS*COLS-1:0] cell_data,
  input logic                 scan_out,
  input logic                 scan_valid
);

  localparam int unsigned CELLS  = ROWS * COLS;
  localparam int unsigned LEVELS = levels_for(CELLS);
  localparam int unsigned LAT    = PIPELINE ? LEVELS : 0;

  logic exp_v;
  logic exp_d;
  logic ref_v;
  logic ref_d;
  int unsigned seen;

  // Flat scan in descending index order: the last hit kept is the lowest index.
  always_comb begin
    exp_v = 1'b0;
    exp_d = 1'b0;
    for (int i = CELLS - 1; i >= 0; i--) begin
      if (row_sel[i / COLS] && col_sel[i % COLS]) begin
        exp_v = 1'b1;
        exp_d = cell_data[i];
      end
    end
  end

  if (PIPELINE) begin : g_hist
    logic [LEVELS:1] hv;
    logic [LEVELS:1] hd;
    always_ff @(posedge clk) begin
      hv[1] <= exp_v;
      hd[1] <= exp_d;
      for (int i = 2; i <= LEVELS; i++) begin
        hv[i] <= hv[i-1];
        hd[i] <= hd[i-1];
      end
    end
    assign ref_v = hv[LEVELS];
    assign ref_d = hd[LEVELS];
  end else begin : g_now
    assign ref_v = exp_v;
    assign ref_d = exp_d;
  end

  always_ff @(posedge clk) begin
    if (rst) seen <= 0;
    else if (seen < LAT) seen <= seen + 1;
  end

  p_valid_align_r5: assert property (@(posedge clk) disable iff (rst)
    (seen >= LAT) |-> (scan_valid == ref_v));

  p_data_pick_r1: assert property (@(posedge clk) disable iff (rst)
    (seen >= LAT && ref_v) |-> (scan_out == ref_d));

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !scan_valid |-> !scan_out);

  p_reset_clear_r6: assert property (@(posedge clk)
    (PIPELINE && $past(rst)) |-> (!scan_valid && !scan_out));

endmodule

bind scan_obs_tree scan_obs_tree_chk #(
  .ROWS(ROWS), .COLS(COLS), .PIPELINE(PIPELINE)
) u_chk (.*);

// File: tb/scan_obs_tree_test.sv
module scan_obs_tree_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [7:0]  row8 = '0;
  logic [7:0]  col8 = '0;
  logic [63:0] dat8 = '0;
  logic [4:0]  row5 = '0;
  logic [4:0]  col5 = '0;
  logic [24:0] dat5 = '0;
  logic        so8, sv8, so5, sv5;

  int tests = 0;
  int fails = 0;

  scan_obs_tree #(.ROWS(8), .COLS(8), .PIPELINE(1'b1)) uut (
    .clk(clk), .rst(rst), .row_sel(row8), .col_sel(col8), .cell_data(dat8),
    .scan_out(so8), .scan_valid(sv8));

  scan_obs_tree #(.ROWS(5), .COLS(5), .PIPELINE(1'b0)) uut_flat (
    .clk(clk), .rst(rst), .row_sel(row5), .col_sel(col5), .cell_data(dat5),
    .scan_out(so5), .scan_valid(sv5));

  // Returns {valid, data}: first hit in ascending index order.
  function automatic logic [1:0] ref_obs(input int nr, input int nc,
      input logic [63:0] rs, input logic [63:0] cs, input logic [63:0] dv);
    for (int i = 0; i < nr * nc; i++) begin
      if (rs[i / nc] && cs[i % nc]) return {1'b1, dv[i]};
    end
    return 2'b00;
  endfunction

  // Reference pipeline for the 8x8 instance: three stages, cleared by reset.
  logic [1:0] pipe [3];
  string      ptag [3];
  string      cur_tag = "R6";

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        pipe[i] <= 2'b00;
        ptag[i] <= "R6";
      end
    end else begin
      pipe[0] <= ref_obs(8, 8, 64'(row8), 64'(col8), dat8);
      ptag[0] <= cur_tag;
      pipe[1] <= pipe[0];
      ptag[1] <= ptag[0];
      pipe[2] <= pipe[1];
      ptag[2] <= ptag[1];
    end
  end

  task automatic check(input logic [1:0] got, input logic [1:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s valid/out actual=%b/%b expected=%b/%b", tag, got[1], got[0], exp[1], exp[0]);
    end
  endtask

  task automatic step(input logic [7:0] r8, input logic [7:0] c8, input logic [63:0] d8,
                      input logic [4:0] r5, input logic [4:0] c5, input logic [24:0] d5,
                      input string tag);
    @(negedge clk);
    check({sv8, so8}, pipe[2], ptag[2]);
    row8 = r8; col8 = c8; dat8 = d8;
    row5 = r5; col5 = c5; dat5 = d5;
    cur_tag = tag;
    #1;
    check({sv5, so5}, ref_obs(5, 5, 64'(r5), 64'(c5), 64'(d5)), {"R7 ", tag});
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R6: selections held during reset are never observed
    for (int i = 0; i < 3; i++)
      step(8'hFF, 8'hFF, rnd64(), 5'h1F, 5'h1F, 25'($urandom), "R6");
    rst = 1'b0;

    // R1 R4 R5: single cells swept back to back, one per cycle
    for (int i = 0; i < 64; i++)
      step(8'(1 << (i / 8)), 8'(1 << (i % 8)), rnd64(),
           5'(1 << ((i / 5) % 5)), 5'(1 << (i % 5)), 25'($urandom), "R1 R4 R5");

    // R2: nothing selected
    for (int i = 0; i < 8; i++)
      step((i % 2) ? 8'($urandom) : 8'h00, (i % 2) ? 8'h00 : 8'($urandom), rnd64(),
           (i % 2) ? 5'h00 : 5'($urandom), (i % 2) ? 5'($urandom) : 5'h00, 25'($urandom), "R2");

    // R3: collisions between several rows and columns
    for (int i = 0; i < 24; i++)
      step(8'($urandom), 8'($urandom), rnd64(), 5'($urandom), 5'($urandom), 25'($urandom), "R3");
    step(8'b1010_0000, 8'b0000_0100, 64'h0000_2000_0000_0000 | 64'h0, 5'b11000, 5'b00010,
         25'h0100000, "R3");

    // R9: unselected cells driven opposite to the selected one (cell 19)
    step(8'h04, 8'h08, ~(64'd1 << 19), 5'h08, 5'h04, ~(25'd1 << 17), "R9");
    step(8'h04, 8'h08, (64'd1 << 19), 5'h08, 5'h04, (25'd1 << 17), "R9");
    step(8'h04, 8'h08, 64'hFFFF_FFFF_FFF7_FFFF, 5'h08, 5'h04, 25'h1FDFFFF, "R9");

    // R8: highest cell in both grids, padded inputs stay inactive
    step(8'h80, 8'h80, 64'd1 << 63, 5'h10, 5'h10, 25'd1 << 24, "R8");
    step(8'h80, 8'h80, 64'd0, 5'h10, 5'h10, 25'd0, "R8");
    step(8'h00, 8'h00, '1, 5'h00, 5'h00, '1, "R8 R2");

    // R6: reset while the pipeline is full
    step(8'h01, 8'h01, '1, 5'h01, 5'h01, '1, "R6");
    step(8'h02, 8'h02, '1, 5'h02, 5'h02, '1, "R6");
    rst = 1'b1;
    step(8'h04, 8'h04, '1, 5'h04, 5'h04, '1, "R6");
    rst = 1'b0;
    for (int i = 0; i < 6; i++)
      step(8'($urandom), 8'($urandom), rnd64(), 5'($urandom), 5'($urandom), 25'($urandom), "R6 R3");

    // flush
    for (int i = 0; i < 4; i++)
      step(8'h00, 8'h00, '0, 5'h00, 5'h00, '0, "R2 R4");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule